// File: doc/BRIEF.md
# Flash Region Protection Checker

This block decides whether a flash read, program or erase may go ahead at a given page and bank. Software sets up eight page-granular regions. Each region has an enable, separate read, program and erase permissions, a base page and a length in pages. A request whose page lands in no enabled region falls back to a default permission set. Whole-bank erases ignore all of that and obey a per-bank erase enable instead.

Every region and every bank configuration carries a lock. The lock opens at reset. Software can close it once, and it stays closed until the next reset; while closed, writes to that configuration are dropped.

A request is one strobe that carries the operation, the page and the bank. The verdict comes back on the next cycle. When a request is refused, the page and the bank of that request are held on the error outputs for software to read.

Top module: `flash_guard`

## Requirements
- R1: After reset, `resp_valid` is 0 and `err_page` and `err_bank` are 0. After reset, every region is disabled, every default permission is off, every bank erase enable is off and every lock is open, so every request is refused.
- R2: `resp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and `resp_allow` carries the verdict in that cycle. `resp_allow` is 0 whenever `resp_valid` is 0.
- R3: A region matches when its enable is set and base <= page < base + size. The sum is formed one bit wider than the page, so a region that runs past the last page does not wrap to page 0. A size of 0 never matches. Regions match pages in either bank. In `rgn_wdata`, bit 0 is the enable, bit 1 is read, bit 2 is program and bit 3 is erase. Bits 12:4 hold the base page and bits 21:13 hold the size.
- R4: When several regions match, the lowest-numbered one alone supplies the permissions, even if it refuses the operation.
- R5: When no enabled region matches, the default set applies. In `dflt_wdata`, bit 0 is read, bit 1 is program and bit 2 is erase.
- R6: `req_op` encodings are 0 = read, 1 = program and 2 = erase. Code 3 is always refused. An erase with `req_bank_erase`=0 is a page erase and needs the erase permission.
- R7: An erase with `req_bank_erase`=1 is allowed exactly when the erase enable of `req_bank` is set, whatever the regions and the default set say.
- R8: A pulse on `rgn_lock_clr` closes the lock of region `rgn_lock_idx`. From then until reset, writes to that region have no effect, and nothing reopens the lock.
- R9: A pulse on `bank_lock_clr` closes the lock of bank `bank_lock_idx`. From then until reset, writes to that bank's erase enable have no effect.
- R10: A refused request loads its page and bank into `err_page` and `err_bank`, which are visible together with the response. An allowed request leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 0 read, 1 program, 2 erase, 3 reserved |
| req_bank_erase | input | 1 | For an erase: 1 = whole bank, 0 = one page |
| req_page | input | 9 | Page of the request |
| req_bank | input | 1 | Bank of the request |
| rgn_wr | input | 1 | Write strobe for a region configuration |
| rgn_idx | input | 3 | Region written |
| rgn_wdata | input | 22 | Region configuration, layout in R3 |
| dflt_wr | input | 1 | Write strobe for the default permissions |
| dflt_wdata | input | 3 | Default permissions, layout in R5 |
| bank_wr | input | 1 | Write strobe for a bank erase enable |
| bank_idx | input | 1 | Bank written |
| bank_wdata | input | 1 | Bank erase enable value |
| rgn_lock_clr | input | 1 | Close the lock of one region |
| rgn_lock_idx | input | 3 | Region to lock |
| bank_lock_clr | input | 1 | Close the lock of one bank |
| bank_lock_idx | input | 1 | Bank to lock |
| resp_valid | output | 1 | Verdict present |
| resp_allow | output | 1 | 1 = operation permitted |
| err_page | output | 9 | Page of the last refused request |
| err_bank | output | 1 | Bank of the last refused request |

## Verification
Any wrong stored state, or a wrong priority between regions, shows up as a wrong `resp_allow` on the cycle right after the first request that touches the affected pages, operation or bank. A broken capture path shows up on `err_page` and `err_bank` in that same cycle. Two faults cannot show on the very request that causes them: a lock that fails to hold, and a base-plus-size sum that wraps. Each is caught by the next sweep of requests over every page, operation and bank. The bench therefore repeats that full sweep after every change of configuration, and again after a second reset.

// File: rtl/flash_guard_pkg.sv
// Package: shared types and field positions of the flash region protection checker.
// Assumes permission vectors keep read in bit 0, program in bit 1 and erase in bit 2.
package flash_guard_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } fg_op_e;

    // Permission triple; packing puts rd at bit 0.
    typedef struct packed {
        logic erase;
        logic prog;
        logic rd;
    } fg_perm_t;

    // Flag positions inside a region write word; base and size follow them.
    localparam int RGN_EN_BIT    = 0;
    localparam int RGN_RD_BIT    = 1;
    localparam int RGN_PROG_BIT  = 2;
    localparam int RGN_ERASE_BIT = 3;
    localparam int RGN_FLAGS_W   = 4;

endpackage

// File: rtl/flash_guard_cfg.sv
// Module: configuration store of the protection checker.
// Holds the region settings, the default permissions and the per-bank erase
// enables, together with the locks that make them read-only once closed.
// Assumes a write and a lock close for the same entry never share a cycle.
module flash_guard_cfg
    import flash_guard_pkg::*;
#(
    parameter int NUM_RGN  = 8,
    parameter int NUM_BANK = 2,
    parameter int PAGE_W   = 9,
    localparam int RGN_IW  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1,
    localparam int BANK_IW = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
    localparam int RGN_DW  = RGN_FLAGS_W + 2 * PAGE_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rgn_wr,
    input  logic [RGN_IW-1:0]                rgn_idx,
    input  logic [RGN_DW-1:0]                rgn_wdata,
    input  logic                             dflt_wr,
    input  logic [2:0]                       dflt_wdata,
    input  logic                             bank_wr,
    input  logic [BANK_IW-1:0]               bank_idx,
    input  logic                             bank_wdata,
    input  logic                             rgn_lock_clr,
    input  logic [RGN_IW-1:0]                rgn_lock_idx,
    input  logic                             bank_lock_clr,
    input  logic [BANK_IW-1:0]               bank_lock_idx,
    output logic [NUM_RGN-1:0]               rgn_en,
    output logic [NUM_RGN-1:0]               rgn_rd,
    output logic [NUM_RGN-1:0]               rgn_prog,
    output logic [NUM_RGN-1:0]               rgn_erase,
    output logic [NUM_RGN-1:0][PAGE_W-1:0]   rgn_base,
    output logic [NUM_RGN-1:0][PAGE_W-1:0]   rgn_size,
    output fg_perm_t                         dflt_perm,
    output logic [NUM_BANK-1:0]              bank_erase_en
);

    logic [NUM_RGN-1:0]  rgn_unlk;
    logic [NUM_BANK-1:0] bank_unlk;

    // Region locks: open at reset, closed once by a lock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgn_unlk <= '1;
        end else begin
            for (int i = 0; i < NUM_RGN; i++) begin
                if (rgn_lock_clr && (rgn_lock_idx == RGN_IW'(i))) rgn_unlk[i] <= 1'b0;
            end
        end
    end

    // Bank locks: open at reset, closed once by a lock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_unlk <= '1;
        end else begin
            for (int b = 0; b < NUM_BANK; b++) begin
                if (bank_lock_clr && (bank_lock_idx == BANK_IW'(b))) bank_unlk[b] <= 1'b0;
            end
        end
    end

    // Region settings: a write lands only in the addressed, unlocked region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgn_en    <= '0;
            rgn_rd    <= '0;
            rgn_prog  <= '0;
            rgn_erase <= '0;
            rgn_base  <= '0;
            rgn_size  <= '0;
        end else begin
            for (int i = 0; i < NUM_RGN; i++) begin
                if (rgn_wr && (rgn_idx == RGN_IW'(i)) && rgn_unlk[i]) begin
                    rgn_en[i]    <= rgn_wdata[RGN_EN_BIT];
                    rgn_rd[i]    <= rgn_wdata[RGN_RD_BIT];
                    rgn_prog[i]  <= rgn_wdata[RGN_PROG_BIT];
                    rgn_erase[i] <= rgn_wdata[RGN_ERASE_BIT];
                    rgn_base[i]  <= rgn_wdata[RGN_FLAGS_W +: PAGE_W];
                    rgn_size[i]  <= rgn_wdata[RGN_FLAGS_W + PAGE_W +: PAGE_W];
                end
            end
        end
    end

    // Default permissions: no lock guards them.
    always_ff @(posedge clk) begin
        if (!rst_n)       dflt_perm <= '0;
        else if (dflt_wr) dflt_perm <= fg_perm_t'(dflt_wdata);
    end

    // Bank erase enables: a write lands only in the addressed, unlocked bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_erase_en <= '0;
        end else begin
            for (int b = 0; b < NUM_BANK; b++) begin
                if (bank_wr && (bank_idx == BANK_IW'(b)) && bank_unlk[b]) bank_erase_en[b] <= bank_wdata;
            end
        end
    end

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn_chk
        assert_rgn_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rgn_unlk[g] |=> !rgn_unlk[g]);
        assert_rgn_locked_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rgn_unlk[g] |=> ($stable(rgn_en[g]) && $stable(rgn_rd[g]) && $stable(rgn_prog[g])
                              && $stable(rgn_erase[g]) && $stable(rgn_base[g]) && $stable(rgn_size[g])));
    end

    for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank_chk
        assert_bank_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !bank_unlk[g] |=> !bank_unlk[g]);
        assert_bank_locked_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !bank_unlk[g] |=> $stable(bank_erase_en[g]));
    end

endmodule

// File: rtl/flash_guard_match.sv
// Module: region matcher of the protection checker, purely combinational.
// Finds every enabled region whose page window holds the page, grants the
// lowest-numbered hit, and yields that region's permissions or the default set.
// Assumes base and size are counted in pages; the end sum is one bit wider.
module flash_guard_match
    import flash_guard_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int PAGE_W  = 9
) (
    input  logic [PAGE_W-1:0]               page,
    input  logic [NUM_RGN-1:0]              rgn_en,
    input  logic [NUM_RGN-1:0]              rgn_rd,
    input  logic [NUM_RGN-1:0]              rgn_prog,
    input  logic [NUM_RGN-1:0]              rgn_erase,
    input  logic [NUM_RGN-1:0][PAGE_W-1:0]  rgn_base,
    input  logic [NUM_RGN-1:0][PAGE_W-1:0]  rgn_size,
    input  fg_perm_t                        dflt_perm,
    output logic [NUM_RGN-1:0]              hit_vec,
    output logic [NUM_RGN-1:0]              sel_vec,
    output fg_perm_t                        perm
);

    // Window test per region, with a widened end so the range never wraps.
    always_comb begin
        logic [PAGE_W:0] lim;
        for (int i = 0; i < NUM_RGN; i++) begin
            lim        = {1'b0, rgn_base[i]} + {1'b0, rgn_size[i]};
            hit_vec[i] = rgn_en[i] && (page >= rgn_base[i]) && ({1'b0, page} < lim);
        end
    end

    // Priority pick: the lowest-numbered hit wins.
    always_comb begin
        logic found;
        found   = 1'b0;
        sel_vec = '0;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (hit_vec[i] && !found) begin
                sel_vec[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    // Permission mux: the granted region or, failing that, the default set.
    always_comb begin
        perm = dflt_perm;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (sel_vec[i]) perm = '{erase: rgn_erase[i], prog: rgn_prog[i], rd: rgn_rd[i]};
        end
    end

endmodule

// File: rtl/flash_guard.sv
// Module: flash region protection checker, top level.
// Decides on each request strobe whether the operation is permitted. It gives
// the verdict one cycle later and keeps the page and bank of the last refusal.
// Assumes a request's fields are steady in the cycle its strobe is high.
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int NUM_RGN  = 8,
    parameter int NUM_BANK = 2,
    parameter int PAGE_W   = 9,
    localparam int RGN_IW  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1,
    localparam int BANK_IW = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
    localparam int RGN_DW  = RGN_FLAGS_W + 2 * PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic                 req_bank_erase,
    input  logic [PAGE_W-1:0]    req_page,
    input  logic [BANK_IW-1:0]   req_bank,
    input  logic                 rgn_wr,
    input  logic [RGN_IW-1:0]    rgn_idx,
    input  logic [RGN_DW-1:0]    rgn_wdata,
    input  logic                 dflt_wr,
    input  logic [2:0]           dflt_wdata,
    input  logic                 bank_wr,
    input  logic [BANK_IW-1:0]   bank_idx,
    input  logic                 bank_wdata,
    input  logic                 rgn_lock_clr,
    input  logic [RGN_IW-1:0]    rgn_lock_idx,
    input  logic                 bank_lock_clr,
    input  logic [BANK_IW-1:0]   bank_lock_idx,
    output logic                 resp_valid,
    output logic                 resp_allow,
    output logic [PAGE_W-1:0]    err_page,
    output logic [BANK_IW-1:0]   err_bank
);

    logic [NUM_RGN-1:0]             rgn_en, rgn_rd, rgn_prog, rgn_erase;
    logic [NUM_RGN-1:0][PAGE_W-1:0] rgn_base, rgn_size;
    fg_perm_t                       dflt_perm, perm;
    logic [NUM_BANK-1:0]            bank_erase_en;
    logic [NUM_RGN-1:0]             hit_vec, sel_vec;
    fg_op_e                         op;
    logic                           allow_d;

    assign op = fg_op_e'(req_op);

    flash_guard_cfg #(
        .NUM_RGN (NUM_RGN),
        .NUM_BANK(NUM_BANK),
        .PAGE_W  (PAGE_W)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .rgn_wr       (rgn_wr),
        .rgn_idx      (rgn_idx),
        .rgn_wdata    (rgn_wdata),
        .dflt_wr      (dflt_wr),
        .dflt_wdata   (dflt_wdata),
        .bank_wr      (bank_wr),
        .bank_idx     (bank_idx),
        .bank_wdata   (bank_wdata),
        .rgn_lock_clr (rgn_lock_clr),
        .rgn_lock_idx (rgn_lock_idx),
        .bank_lock_clr(bank_lock_clr),
        .bank_lock_idx(bank_lock_idx),
        .rgn_en       (rgn_en),
        .rgn_rd       (rgn_rd),
        .rgn_prog     (rgn_prog),
        .rgn_erase    (rgn_erase),
        .rgn_base     (rgn_base),
        .rgn_size     (rgn_size),
        .dflt_perm    (dflt_perm),
        .bank_erase_en(bank_erase_en)
    );

    flash_guard_match #(
        .NUM_RGN(NUM_RGN),
        .PAGE_W (PAGE_W)
    ) u_match (
        .page     (req_page),
        .rgn_en   (rgn_en),
        .rgn_rd   (rgn_rd),
        .rgn_prog (rgn_prog),
        .rgn_erase(rgn_erase),
        .rgn_base (rgn_base),
        .rgn_size (rgn_size),
        .dflt_perm(dflt_perm),
        .hit_vec  (hit_vec),
        .sel_vec  (sel_vec),
        .perm     (perm)
    );

    // Verdict: bank erase obeys the bank enable only, the rest obey the matched permissions.
    always_comb begin
        case (op)
            OP_READ:  allow_d = perm.rd;
            OP_PROG:  allow_d = perm.prog;
            OP_ERASE: allow_d = req_bank_erase ? bank_erase_en[req_bank] : perm.erase;
            default:  allow_d = 1'b0;
        endcase
    end

    // Response register: verdict one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_allow <= req_valid && allow_d;
        end
    end

    // Error capture: page and bank of every refused request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_page <= '0;
            err_bank <= '0;
        end else if (req_valid && !allow_d) begin
            err_page <= req_page;
            err_bank <= req_bank;
        end
    end

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    assert_no_resp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !resp_allow));
    assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_vec) && ((sel_vec & ~hit_vec) == '0));
    assert_grant_when_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |-> (sel_vec != '0));
    assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_vec - 1'b1) & hit_vec) == '0);
    assert_rsvd_denied_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> !resp_allow);
    assert_bank_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2 && req_bank_erase) |=> (resp_allow == $past(bank_erase_en[req_bank])));
    assert_err_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_allow) |-> (err_page == $past(req_page) && err_bank == $past(req_bank)));
    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && !resp_allow) |-> ($stable(err_page) && $stable(err_bank)));

endmodule

// File: tb/flash_guard_tb.sv
// Bench: sweeps every page, operation, scope and bank against an arithmetic model.
module flash_guard_tb;

    localparam int NR = 8;
    localparam int NB = 2;
    localparam int PW = 9;
    localparam int NPAGE = 1 << PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_bank_erase = 0, rgn_wr = 0, dflt_wr = 0, bank_wr = 0;
    logic bank_wdata = 0, rgn_lock_clr = 0, bank_lock_clr = 0;
    logic [1:0] req_op = 0;
    logic [PW-1:0] req_page = 0;
    logic [0:0] req_bank = 0, bank_idx = 0, bank_lock_idx = 0;
    logic [2:0] rgn_idx = 0, rgn_lock_idx = 0, dflt_wdata = 0;
    logic [21:0] rgn_wdata = 0;
    logic resp_valid, resp_allow;
    logic [PW-1:0] err_page;
    logic [0:0] err_bank;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Model of the configuration
    bit m_en[NR], m_rd[NR], m_pg[NR], m_er[NR], m_unlk[NR];
    int m_base[NR], m_size[NR];
    bit m_dflt[3];
    bit m_ben[NB], m_bunlk[NB];
    int e_page, e_bank;

    always #10 clk = ~clk;

    flash_guard u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank_erase(req_bank_erase), .req_page(req_page), .req_bank(req_bank),
        .rgn_wr(rgn_wr), .rgn_idx(rgn_idx), .rgn_wdata(rgn_wdata),
        .dflt_wr(dflt_wr), .dflt_wdata(dflt_wdata), .bank_wr(bank_wr),
        .bank_idx(bank_idx), .bank_wdata(bank_wdata), .rgn_lock_clr(rgn_lock_clr),
        .rgn_lock_idx(rgn_lock_idx), .bank_lock_clr(bank_lock_clr),
        .bank_lock_idx(bank_lock_idx), .resp_valid(resp_valid), .resp_allow(resp_allow),
        .err_page(err_page), .err_bank(err_bank)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) begin
            m_en[i] = 0; m_rd[i] = 0; m_pg[i] = 0; m_er[i] = 0;
            m_base[i] = 0; m_size[i] = 0; m_unlk[i] = 1;
        end
        for (int i = 0; i < 3; i++) m_dflt[i] = 0;
        for (int b = 0; b < NB; b++) begin m_ben[b] = 0; m_bunlk[b] = 1; end
        e_page = 0; e_bank = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
        chk(err_page == '0, "R1", "err_page after reset", err_page, 0);
        chk(err_bank == '0, "R1", "err_bank after reset", err_bank, 0);
    endtask

    task automatic wr_rgn(int idx, bit en, bit rd, bit pg, bit er, int base, int size);
        rgn_idx = 3'(idx);
        rgn_wdata = {9'(size), 9'(base), er, pg, rd, en};
        rgn_wr = 1'b1;
        @(negedge clk);
        rgn_wr = 1'b0;
        if (m_unlk[idx]) begin
            m_en[idx] = en; m_rd[idx] = rd; m_pg[idx] = pg; m_er[idx] = er;
            m_base[idx] = base; m_size[idx] = size;
        end
    endtask

    task automatic wr_dflt(bit rd, bit pg, bit er);
        dflt_wdata = {er, pg, rd};
        dflt_wr = 1'b1;
        @(negedge clk);
        dflt_wr = 1'b0;
        m_dflt[0] = rd; m_dflt[1] = pg; m_dflt[2] = er;
    endtask

    task automatic wr_bank(int b, bit v);
        bank_idx = 1'(b);
        bank_wdata = v;
        bank_wr = 1'b1;
        @(negedge clk);
        bank_wr = 1'b0;
        if (m_bunlk[b]) m_ben[b] = v;
    endtask

    task automatic lock_rgn(int idx);
        rgn_lock_idx = 3'(idx);
        rgn_lock_clr = 1'b1;
        @(negedge clk);
        rgn_lock_clr = 1'b0;
        m_unlk[idx] = 0;
    endtask

    task automatic lock_bank(int b);
        bank_lock_idx = 1'(b);
        bank_lock_clr = 1'b1;
        @(negedge clk);
        bank_lock_clr = 1'b0;
        m_bunlk[b] = 0;
    endtask

    function automatic bit exp_allow(int page, int op, bit be, int bank, output string tag);
        int hits = 0;
        int first = -1;
        if (op == 3) begin tag = "R6"; return 1'b0; end
        if (op == 2 && be) begin tag = "R7"; return m_ben[bank]; end
        for (int i = 0; i < NR; i++) begin
            if (m_en[i] && page >= m_base[i] && page < m_base[i] + m_size[i]) begin
                hits++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) begin
            tag = "R5";
            return m_dflt[op];
        end
        tag = (hits > 1) ? "R4" : "R3";
        case (op)
            0: return m_rd[first];
            1: return m_pg[first];
            default: return m_er[first];
        endcase
    endfunction

    task automatic do_req(int page, int op, bit be, int bank, string phase);
        string tag;
        bit exp;
        exp = exp_allow(page, op, be, bank, tag);
        req_page = PW'(page); req_op = 2'(op); req_bank_erase = be; req_bank = 1'(bank);
        req_valid = 1'b1;
        @(negedge clk);
        if (!exp) begin e_page = page; e_bank = bank; end
        chk(resp_valid == 1'b1, "R2", "resp_valid on response cycle", resp_valid, 1);
        if (resp_allow !== exp)
            $display("  at %s page %0d op %0d scope %0d bank %0d", phase, page, op, be, bank);
        chk(resp_allow === exp, tag, "resp_allow", resp_allow, exp);
        chk(err_page == PW'(e_page) && err_bank == 1'(e_bank), "R10", "err page*2+bank",
            int'(err_page) * 2 + int'(err_bank), e_page * 2 + e_bank);
        req_valid = 1'b0;
        @(negedge clk);
        chk(resp_valid == 1'b0 && resp_allow == 1'b0, "R2", "response idle", resp_valid, 0);
    endtask

    task automatic sweep(string phase);
        for (int p = 0; p < NPAGE; p++)
            for (int op = 0; op < 4; op++)
                for (int be = 0; be < 2; be++)
                    for (int b = 0; b < NB; b++)
                        do_req(p, op, 1'(be), b, phase);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R2: actual 0 expected 1 (run did not complete)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: nothing configured, everything refused
        do_req(0, 0, 0, 0, "R1 reset");
        do_req(511, 2, 1, 1, "R1 reset");

        // R3 R4 R5 R6 R7: overlapping, disabled, empty, edge and wrapping windows
        wr_rgn(0, 1, 1, 0, 0, 10, 20);
        wr_rgn(1, 1, 1, 1, 1, 0, 64);
        wr_rgn(2, 0, 1, 1, 1, 100, 50);
        wr_rgn(3, 1, 0, 1, 0, 500, 20);
        wr_rgn(4, 1, 1, 1, 1, 200, 0);
        wr_rgn(5, 1, 0, 0, 1, 256, 1);
        wr_rgn(6, 1, 1, 0, 0, 511, 1);
        wr_dflt(0, 1, 0);
        wr_bank(0, 1);
        sweep("config A");

        // R8 R9: lock region 1 and bank 0, then try to change them
        lock_rgn(1);
        lock_bank(0);
        wr_rgn(1, 0, 0, 0, 0, 300, 5);
        wr_bank(0, 0);
        lock_rgn(1);
        wr_rgn(1, 1, 0, 0, 0, 0, 1);
        wr_rgn(0, 1, 0, 1, 1, 40, 40);
        wr_bank(1, 1);
        wr_dflt(1, 0, 1);
        sweep("R8 R9 locked");

        // R1 R8 R9: a second reset reopens locks and clears everything
        do_reset();
        wr_rgn(1, 1, 1, 0, 0, 5, 3);
        wr_bank(0, 1);
        sweep("R1 R8 after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule